// File: doc/BRIEF.md
# Card Reply Frame Transmitter

This block sits on the card side of a proximity link. When the receive path has gathered a frame from the reader, it hands over the frame's bit count and data word with a one-cycle strobe. The block compares both values against a small table of known queries that is fixed by parameters. If an entry matches, the block waits a fixed number of time-base ticks and then sends the paired reply on a single serial line. Each bit is held for a fixed number of ticks, the least significant bit goes first, and the line carries the raw bit level with no coding.

All timing comes from a tick-enable input, which is normally the system clock divided by 32. The block counts only the cycles in which the tick is high. A busy flag covers the whole answer, from the accepted strobe to the end of the last bit period. A one-cycle done pulse marks the end of the answer. Strobes that arrive while the block is busy are dropped.

Top module: `card_reply_tx`

## Requirements
- R1: With its default table, a 7-bit frame of value 0x55 is answered with the 6-bit reply 0x3B.
- R2: A reply is sent only when the frame count and the whole frame data word both equal those of a table entry. Any other frame leaves busy low and the line low.
- R3: A table entry whose query count is 0 is disabled and never matches, even for a 0-bit frame of data 0.
- R4: When several entries match, the entry with the lowest index supplies the reply.
- R5: After an accepted strobe the line stays low for TURN_TICKS ticks. Bit 0 appears after the clock edge that samples the TURN_TICKS-th tick following the strobe edge.
- R6: Each reply bit is held for BIT_TICKS ticks. Bits leave in order from bit 0 upward, with the line high for a 1 and low for a 0.
- R7: Busy rises at the edge that accepts the strobe and falls at the edge that ends the last bit period. The line is low whenever busy is low.
- R8: A strobe that arrives while busy is high has no effect on the reply waveform or on the time busy falls.
- R9: Done is high for exactly one cycle, in the cycle right after the edge that ends the last bit period.
- R10: Only cycles with tick_en high advance the turnaround and bit timing. Gaps between ticks stretch the waveform without changing its shape.
- R11: After reset, busy, done and the line are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Time-base enable, one cycle per tick |
| frame_valid | input | 1 | One-cycle strobe: a received frame is ready |
| frame_cnt | input | CNT_W | Number of bits in the received frame |
| frame_data | input | DATA_W | Received frame bits, first bit at position 0 |
| tx_out | output | 1 | Serial reply line |
| busy | output | 1 | High while a reply is waiting or being sent |
| done | output | 1 | One-cycle pulse at the end of a reply |

## Verification
The bench uses a four-entry table with a short turnaround and bit time. Two entries hold the same query, so a reply of the wrong length shows at once that the priority rule is broken. A third entry uses the full 16-bit reply width, and a fourth entry is disabled.

Matching frames are compared cycle by cycle against a tick-counting model, with the tick given on every cycle, every second cycle and every third cycle; this separates cycle counting from tick counting. Frames that almost match differ in only the count or only the data bits above the frame length. Two sweeps cover every 7-bit value at count 7 and every count at value 0x55, and these must all stay silent except the one true query. A second matching strobe sent during an answer must leave the waveform unchanged.

// File: rtl/card_reply_pkg.sv
package card_reply_pkg;

   typedef enum logic [1:0] {
      RS_IDLE = 2'd0,
      RS_WAIT = 2'd1,
      RS_SEND = 2'd2
   } reply_state_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/reply_match.sv
module reply_match #(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned DATA_W      = 16,
   parameter logic [NUM_ENTRIES*CNT_W-1:0]  Q_CNT_TBL  = '0,
   parameter logic [NUM_ENTRIES*DATA_W-1:0] Q_DATA_TBL = '0,
   parameter logic [NUM_ENTRIES*CNT_W-1:0]  R_CNT_TBL  = '0,
   parameter logic [NUM_ENTRIES*DATA_W-1:0] R_DATA_TBL = '0
) (
   input  logic [CNT_W-1:0]  frame_cnt,
   input  logic [DATA_W-1:0] frame_data,
   output logic              hit,
   output logic [CNT_W-1:0]  rsp_cnt,
   output logic [DATA_W-1:0] rsp_data
);

   logic [NUM_ENTRIES-1:0] hit_vec;
   logic [CNT_W-1:0]       rc_arr [NUM_ENTRIES];
   logic [DATA_W-1:0]      rd_arr [NUM_ENTRIES];

   // one comparator per table entry; a zero query count disables the entry
   generate
      for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_entry
         localparam logic [CNT_W-1:0]  QC = Q_CNT_TBL[gi*CNT_W +: CNT_W];
         localparam logic [DATA_W-1:0] QD = Q_DATA_TBL[gi*DATA_W +: DATA_W];
         if (QC == '0) begin : g_off
            assign hit_vec[gi] = 1'b0;
         end else begin : g_on
            assign hit_vec[gi] = (frame_cnt == QC) && (frame_data == QD);
         end
         assign rc_arr[gi] = R_CNT_TBL[gi*CNT_W +: CNT_W];
         assign rd_arr[gi] = R_DATA_TBL[gi*DATA_W +: DATA_W];
      end
   endgenerate

   // lowest index wins: scan from the top so lower entries overwrite
   always_comb begin
      rsp_cnt  = '0;
      rsp_data = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            rsp_cnt  = rc_arr[i];
            rsp_data = rd_arr[i];
         end
      end
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/reply_pacer.sv
module reply_pacer
   import card_reply_pkg::*;
#(
   parameter int unsigned TURN_TICKS = 490,
   parameter int unsigned BIT_TICKS  = 150
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_en,
   input  logic         start,
   input  logic         last_bit,
   output reply_state_e state,
   output logic         bit_end,
   output logic         busy,
   output logic         done
);

   localparam int unsigned TMAX  = max_of(TURN_TICKS, BIT_TICKS);
   localparam int unsigned CTR_W = $clog2(TMAX + 1);
   localparam logic [CTR_W-1:0] TURN_LAST = CTR_W'(TURN_TICKS - 1);
   localparam logic [CTR_W-1:0] BIT_LAST  = CTR_W'(BIT_TICKS - 1);

   reply_state_e     state_q;
   logic [CTR_W-1:0] tick_cnt_q;
   logic             done_q;

   assign bit_end = (state_q == RS_SEND) && tick_en && (tick_cnt_q == BIT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= RS_IDLE;
         tick_cnt_q <= '0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RS_IDLE: begin
               if (start) begin
                  state_q    <= RS_WAIT;
                  tick_cnt_q <= '0;
               end
            end
            RS_WAIT: begin
               if (tick_en) begin
                  if (tick_cnt_q == TURN_LAST) begin
                     state_q    <= RS_SEND;
                     tick_cnt_q <= '0;
                  end else begin
                     tick_cnt_q <= tick_cnt_q + 1'b1;
                  end
               end
            end
            RS_SEND: begin
               if (tick_en) begin
                  if (tick_cnt_q == BIT_LAST) begin
                     tick_cnt_q <= '0;
                     if (last_bit) begin
                        state_q <= RS_IDLE;
                        done_q  <= 1'b1;
                     end
                  end else begin
                     tick_cnt_q <= tick_cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               state_q    <= RS_IDLE;
               tick_cnt_q <= '0;
            end
         endcase
      end
   end

   assign state = state_q;
   assign busy  = (state_q != RS_IDLE);
   assign done  = done_q;

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick_en && !done) |=> $stable(tick_cnt_q) && $stable(state_q));

endmodule

// File: rtl/reply_shifter.sv
module reply_shifter
   import card_reply_pkg::*;
#(
   parameter int unsigned CNT_W  = 5,
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  rsp_cnt,
   input  logic [DATA_W-1:0] rsp_data,
   input  reply_state_e      state,
   input  logic              bit_end,
   output logic              last_bit,
   output logic              tx_bit
);

   logic [DATA_W-1:0] sreg_q;
   logic [CNT_W-1:0]  left_q;

   assign last_bit = (left_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         left_q <= '0;
      end else if (load) begin
         sreg_q <= rsp_data;
         left_q <= rsp_cnt;
      end else if (bit_end && !last_bit) begin
         sreg_q <= sreg_q >> 1;
         left_q <= left_q - 1'b1;
      end
   end

   assign tx_bit = (state == RS_SEND) ? sreg_q[0] : 1'b0;

   // R5
   wait_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != RS_SEND) |-> !tx_bit);

   // R6
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RS_SEND && !bit_end) |=> $stable(tx_bit));

endmodule

// File: rtl/card_reply_tx.sv
module card_reply_tx
   import card_reply_pkg::*;
#(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TURN_TICKS  = 490,
   parameter int unsigned BIT_TICKS   = 150,
   parameter logic [NUM_ENTRIES*CNT_W-1:0]  Q_CNT_TBL  = {{(NUM_ENTRIES-1)*CNT_W{1'b0}}, CNT_W'(7)},
   parameter logic [NUM_ENTRIES*DATA_W-1:0] Q_DATA_TBL = {{(NUM_ENTRIES-1)*DATA_W{1'b0}}, DATA_W'(8'h55)},
   parameter logic [NUM_ENTRIES*CNT_W-1:0]  R_CNT_TBL  = {{(NUM_ENTRIES-1)*CNT_W{1'b0}}, CNT_W'(6)},
   parameter logic [NUM_ENTRIES*DATA_W-1:0] R_DATA_TBL = {{(NUM_ENTRIES-1)*DATA_W{1'b0}}, DATA_W'(8'h3B)}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              frame_valid,
   input  logic [CNT_W-1:0]  frame_cnt,
   input  logic [DATA_W-1:0] frame_data,
   output logic              tx_out,
   output logic              busy,
   output logic              done
);

   // elaboration-time parameter checks
   generate
      if (NUM_ENTRIES < 1)                  begin : g_bad_n    $error("NUM_ENTRIES must be at least 1"); end
      if (DATA_W < 1)                       begin : g_bad_w    $error("DATA_W must be at least 1"); end
      if (CNT_W < $clog2(DATA_W + 1))       begin : g_bad_cw   $error("CNT_W too narrow for DATA_W"); end
      if (TURN_TICKS < 1 || BIT_TICKS < 1)  begin : g_bad_t    $error("tick counts must be at least 1"); end
      for (genvar gk = 0; gk < NUM_ENTRIES; gk++) begin : g_tbl_chk
         if (Q_CNT_TBL[gk*CNT_W +: CNT_W] != '0 &&
             (R_CNT_TBL[gk*CNT_W +: CNT_W] == '0 ||
              R_CNT_TBL[gk*CNT_W +: CNT_W] > CNT_W'(DATA_W))) begin : g_bad_r
            $error("enabled entry needs a reply length of 1..DATA_W");
         end
         if (Q_CNT_TBL[gk*CNT_W +: CNT_W] > CNT_W'(DATA_W)) begin : g_bad_q
            $error("query length exceeds DATA_W");
         end
      end
   endgenerate

   logic              hit;
   logic [CNT_W-1:0]  rsp_cnt;
   logic [DATA_W-1:0] rsp_data;
   logic              start;
   logic              last_bit;
   logic              bit_end;
   reply_state_e      state;

   reply_match #(
      .NUM_ENTRIES (NUM_ENTRIES),
      .CNT_W       (CNT_W),
      .DATA_W      (DATA_W),
      .Q_CNT_TBL   (Q_CNT_TBL),
      .Q_DATA_TBL  (Q_DATA_TBL),
      .R_CNT_TBL   (R_CNT_TBL),
      .R_DATA_TBL  (R_DATA_TBL)
   ) match_i (
      .frame_cnt  (frame_cnt),
      .frame_data (frame_data),
      .hit        (hit),
      .rsp_cnt    (rsp_cnt),
      .rsp_data   (rsp_data)
   );

   // strobes are taken only when idle
   assign start = frame_valid && hit && (state == RS_IDLE);

   reply_pacer #(
      .TURN_TICKS (TURN_TICKS),
      .BIT_TICKS  (BIT_TICKS)
   ) pacer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .start    (start),
      .last_bit (last_bit),
      .state    (state),
      .bit_end  (bit_end),
      .busy     (busy),
      .done     (done)
   );

   reply_shifter #(
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W)
   ) shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .rsp_cnt  (rsp_cnt),
      .rsp_data (rsp_data),
      .state    (state),
      .bit_end  (bit_end),
      .last_bit (last_bit),
      .tx_bit   (tx_out)
   );

   // R7
   idle_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tx_out);

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));

   // R8
   busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_valid && !bit_end) |=> busy);

endmodule

// File: tb/card_reply_tx_tb_top.sv
module card_reply_tx_tb_top;

   localparam int CLK_P  = 10;
   localparam int NE     = 4;
   localparam int CW     = 5;
   localparam int DW     = 16;
   localparam int TURN   = 5;
   localparam int BITT   = 2;

   // e0: 7/0x55 -> 6/0x3B ; e1: 7/0x55 -> 2/0x3 (shadowed) ;
   // e2: 16/0xFFFF -> 16/0x8001 ; e3: disabled (query count 0)
   localparam logic [NE*CW-1:0] QC = {5'd0, 5'd16, 5'd7, 5'd7};
   localparam logic [NE*DW-1:0] QD = {16'h0000, 16'hFFFF, 16'h0055, 16'h0055};
   localparam logic [NE*CW-1:0] RC = {5'd5, 5'd16, 5'd2, 5'd6};
   localparam logic [NE*DW-1:0] RD = {16'h001F, 16'h8001, 16'h0003, 16'h003B};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          frame_valid = 1'b0;
   logic [CW-1:0] frame_cnt = '0;
   logic [DW-1:0] frame_data = '0;
   logic          tx_out, busy, done;

   int n_checks = 0;
   int n_errors = 0;

   always #(CLK_P/2) clk = ~clk;

   card_reply_tx #(
      .NUM_ENTRIES (NE), .CNT_W (CW), .DATA_W (DW),
      .TURN_TICKS (TURN), .BIT_TICKS (BITT),
      .Q_CNT_TBL (QC), .Q_DATA_TBL (QD), .R_CNT_TBL (RC), .R_DATA_TBL (RD)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
      .frame_valid (frame_valid), .frame_cnt (frame_cnt), .frame_data (frame_data),
      .tx_out (tx_out), .busy (busy), .done (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [2:0] act, input logic [2:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: got {tx,busy,done}=%b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // full reply run checked every cycle against a tick-counting model
   task automatic run_frame(input int qc, input logic [DW-1:0] qd, input bit hit,
                            input int rc, input logic [DW-1:0] rd, input int per,
                            input bit poke, input string req);
      int k = 0;
      int cyc = 0;
      int after = 0;
      int total;
      bit tk;
      bit just_end = 0;
      logic [2:0] exp;
      total = hit ? TURN + rc * BITT : 0;
      @(negedge clk);
      frame_cnt = CW'(qc); frame_data = qd; frame_valid = 1'b1; tick_en = 1'b0;
      @(negedge clk);
      frame_valid = 1'b0;
      while (after < 3) begin
         exp[2] = (k >= TURN && k < total) ? rd[(k - TURN) / BITT] : 1'b0;
         exp[1] = (k < total);
         exp[0] = just_end;
         check({tx_out, busy, done} === exp, req, "reply waveform", {tx_out, busy, done}, exp);
         tk = ((cyc % per) == 0);
         tick_en = tk;
         if (poke && cyc == 3) begin
            frame_cnt = CW'(16); frame_data = 16'hFFFF; frame_valid = 1'b1;
         end
         @(posedge clk);
         just_end = 0;
         if (tk && k < total) begin
            k++;
            just_end = (k == total);
         end
         if (k >= total) after++;
         @(negedge clk);
         frame_valid = 1'b0;
         cyc++;
      end
      tick_en = 1'b0;
   endtask

   // frame that must not be answered
   task automatic quiet_frame(input int qc, input logic [DW-1:0] qd, input string req);
      @(negedge clk);
      frame_cnt = CW'(qc); frame_data = qd; frame_valid = 1'b1; tick_en = 1'b1;
      @(negedge clk);
      frame_valid = 1'b0;
      check({tx_out, busy, done} === 3'b000, req, "no reply expected", {tx_out, busy, done}, 3'b000);
      @(negedge clk);
      check({tx_out, busy, done} === 3'b000, req, "still silent", {tx_out, busy, done}, 3'b000);
      tick_en = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      n_errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check({tx_out, busy, done} === 3'b000, "R11", "during reset", {tx_out, busy, done}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      check({tx_out, busy, done} === 3'b000, "R11", "after reset", {tx_out, busy, done}, 3'b000);

      // R1 R4 R5 R6 R7 R9: main query, tick every cycle, e0 beats shadow e1
      run_frame(7, 16'h0055, 1'b1, 6, 16'h003B, 1, 1'b0, "R1/R4/R5/R6/R7/R9");
      // R10 sparse ticks
      run_frame(7, 16'h0055, 1'b1, 6, 16'h003B, 3, 1'b0, "R10");
      run_frame(7, 16'h0055, 1'b1, 6, 16'h003B, 2, 1'b0, "R10");
      // R6 full-width reply
      run_frame(16, 16'hFFFF, 1'b1, 16, 16'h8001, 2, 1'b0, "R6");
      // R8 strobe while busy ignored
      run_frame(7, 16'h0055, 1'b1, 6, 16'h003B, 1, 1'b1, "R8");
      // R2 near misses
      quiet_frame(6, 16'h0055, "R2");
      quiet_frame(7, 16'h00D5, "R2");
      quiet_frame(7, 16'h1055, "R2");
      // R3 disabled entry
      quiet_frame(0, 16'h0000, "R3");
      // R2 sweep of all 7-bit values at count 7
      for (int v = 0; v < 128; v++) begin
         if (v != 8'h55) quiet_frame(7, DW'(v), "R2");
      end
      // R2 sweep of counts at value 0x55
      for (int c = 0; c < 32; c++) begin
         if (c != 7) quiet_frame(c, 16'h0055, "R2");
      end
      // R1 still answered after the sweeps
      run_frame(7, 16'h0055, 1'b1, 6, 16'h003B, 1, 1'b0, "R1");

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule